// File: doc/BRIEF.md
# Endpoint DMA Channel with Descriptor Chaining

This block is one DMA channel that moves bytes between system memory and a device endpoint FIFO. Software programs a buffer address, a byte count and a set of control flags through a four-entry register window, then enables the channel. The channel runs the buffer one byte at a time. In the memory-to-endpoint direction it reads memory and pushes bytes onto an outbound stream. In the endpoint-to-memory direction it takes bytes from an inbound stream and writes them to memory.

When a buffer ends, the channel can load a three-word descriptor from memory and carry on with the next buffer without software help. A chain whose last descriptor has load-next clear leaves the channel enabled and idle, ready for software to chain more work. Software can make an enabled endpoint interrupt, such as an error, abort the running transfer. Each finished buffer can raise an interrupt line.

Two rules govern the memory port. A single read/write port serves both descriptor fetches and data beats. At most one beat is in flight on it at any time.

Top module: `ep_dma_channel`

## Requirements
- R1: After a synchronous reset, all of these read as zero: mem_req, out_valid, in_ready and dma_irq, plus every register.
- R2: Register index 0 holds the next-descriptor address, 1 the buffer address and 2 the control word. Read data appears on reg_rdata one cycle after reg_rd. The control word layout is: bit 0 enable, bit 1 load-next, bit 2 end-of-buffer interrupt enable, bit 3 stop-on-endpoint-interrupt, bit 4 direction (1 means memory to endpoint), and bits 31:16 byte count.
- R3: Register writes are ignored while the channel is active, so a descriptor can only be chained while the channel is stopped.
- R4: In the memory-to-endpoint direction, each byte is one memory read at the buffer address, taking bits 7:0 of the read data. The byte is held on out_data with out_valid until out_ready. After each byte the buffer address goes up by one and the count goes down by one.
- R5: In the endpoint-to-memory direction, each byte is taken when in_ready and in_valid are both high. It is then written to memory in bits 7:0 of mem_wdata at the buffer address.
- R6: Once mem_req is raised, it stays high with the address, write strobe and write data held stable until mem_ack. No new beat or descriptor fetch starts before that ack.
- R7: A descriptor is three 32-bit words read at base, base+4 and base+8: next address, buffer address, control word. The base is the next-descriptor register. A fetch happens when a buffer ends with load-next set. It also happens when software writes a control word with enable clear and load-next set. A fetched control word with enable clear stops the channel.
- R8: A buffer with a byte count of zero completes at once, with no memory access.
- R9: When a buffer ends with load-next clear, the channel goes idle, keeps enable set and flags end-of-transfer.
- R10: If the stop bit is set and ep_irq is high, the channel aborts at the next byte boundary. It clears enable, flags end-of-transfer and keeps the remaining count. With the stop bit clear, ep_irq has no effect.
- R11: Each finished buffer sets the end-of-buffer flag. If that buffer's interrupt enable was set, dma_irq is also raised.
- R12: The status register is index 3. Bit 0 is enable, bit 1 active, bit 2 end-of-transfer, bit 3 end-of-buffer, and bits 31:16 the remaining count. Reading it clears both event flags and dma_irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after reg_rd |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 32 | Byte address of the beat |
| mem_wdata | output | 32 | Write data, byte in bits 7:0 |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Beat completion |
| out_valid | output | 1 | Outbound byte valid |
| out_data | output | 8 | Outbound byte |
| out_ready | input | 1 | Endpoint accepts outbound byte |
| in_valid | input | 1 | Inbound byte valid |
| in_data | input | 8 | Inbound byte |
| in_ready | output | 1 | Channel accepts inbound byte |
| ep_irq | input | 1 | An enabled endpoint interrupt is pending |
| dma_irq | output | 1 | End-of-buffer interrupt |

## Verification
The assertions check on every cycle that:
- memory and outbound stream requests stay stable until they are accepted;
- a zero-count buffer issues no beat;
- an abort drops enable in the following cycle;
- the next-descriptor register moves only through a fetch while the channel is active;
- dma_irq follows its set and read-clear rules.

Some behaviours only the bench scenarios can show:
- the byte contents moved in both directions across randomly stalled memory and stream handshakes;
- the order in which descriptors are walked, and the total count of memory accesses across a chain that contains an empty buffer;
- the remaining count left after an abort;
- that register writes issued mid-transfer leave the programmed values unchanged.

// File: rtl/ep_dma_pkg.sv
package ep_dma_pkg;

  localparam int BYTE_W = 8;

  // control word flag positions (count field sits in the top bits)
  localparam int CTL_EN   = 0;
  localparam int CTL_LD   = 1;
  localparam int CTL_IE   = 2;
  localparam int CTL_STOP = 3;
  localparam int CTL_DIR  = 4;

  // register indices
  localparam logic [1:0] RIDX_NEXT = 2'd0;
  localparam logic [1:0] RIDX_BUF  = 2'd1;
  localparam logic [1:0] RIDX_CTRL = 2'd2;
  localparam logic [1:0] RIDX_STAT = 2'd3;

  localparam int DESC_WORDS = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_RD,
    ST_PUSH,
    ST_WAITIN,
    ST_WR,
    ST_BDONE,
    ST_FETCH
  } ch_state_t;

endpackage

// File: rtl/ep_dma_regs.sv
module ep_dma_regs
  import ep_dma_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          active,
  input  logic          chan_en,
  input  logic [AW-1:0] next_addr,
  input  logic [AW-1:0] buf_addr,
  input  logic [DW-1:0] ctrl_word,
  input  logic [CW-1:0] remain,
  input  logic          ev_eob,
  input  logic          ev_eob_irq,
  input  logic          ev_eot,
  output logic          sw_wr_next,
  output logic          sw_wr_buf,
  output logic          sw_wr_ctrl,
  output logic          dma_irq
);

  localparam int PAD_W = DW - CW - 4;

  logic eot_q, eob_q, irq_q;
  logic rd_status;
  logic [DW-1:0] status_word;

  // writes only land while the channel is stopped
  assign sw_wr_next = reg_wr && !active && (reg_addr == RIDX_NEXT);
  assign sw_wr_buf  = reg_wr && !active && (reg_addr == RIDX_BUF);
  assign sw_wr_ctrl = reg_wr && !active && (reg_addr == RIDX_CTRL);
  assign rd_status  = reg_rd && (reg_addr == RIDX_STAT);

  assign status_word = {remain, {PAD_W{1'b0}}, eob_q, eot_q, active, chan_en};

  always_ff @(posedge clk) begin
    if (rst) begin
      eot_q     <= 1'b0;
      eob_q     <= 1'b0;
      irq_q     <= 1'b0;
      reg_rdata <= '0;
    end else begin
      eot_q <= ev_eot     | (eot_q & !rd_status);
      eob_q <= ev_eob     | (eob_q & !rd_status);
      irq_q <= ev_eob_irq | (irq_q & !rd_status);
      if (reg_rd) begin
        unique case (reg_addr)
          RIDX_NEXT: reg_rdata <= DW'(next_addr);
          RIDX_BUF:  reg_rdata <= DW'(buf_addr);
          RIDX_CTRL: reg_rdata <= ctrl_word;
          default:   reg_rdata <= status_word;
        endcase
      end
    end
  end

  assign dma_irq = irq_q;

  // R11
  irq_set_chk: assert property (@(posedge clk) disable iff (rst)
    ev_eob_irq |=> dma_irq);

  // R12
  irq_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_status && !ev_eob_irq) |=> !dma_irq);

  // R12
  eob_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_status && !ev_eob) |=> !eob_q);

endmodule

// File: rtl/ep_dma_engine.sv
module ep_dma_engine
  import ep_dma_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sw_wr_next,
  input  logic              sw_wr_buf,
  input  logic              sw_wr_ctrl,
  input  logic [DW-1:0]     sw_wdata,
  input  logic              ep_irq,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_wdata,
  input  logic [DW-1:0]     mem_rdata,
  input  logic              mem_ack,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data,
  input  logic              out_ready,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  output logic              in_ready,
  output logic [AW-1:0]     next_addr,
  output logic [AW-1:0]     buf_addr,
  output logic [DW-1:0]     ctrl_word,
  output logic [CW-1:0]     remain,
  output logic              active,
  output logic              chan_en,
  output logic              ev_eob,
  output logic              ev_eob_irq,
  output logic              ev_eot
);

  localparam int WORD_BYTES = DW / 8;
  localparam int FIDX_W     = $clog2(DESC_WORDS);
  localparam int CNT_MSB    = DW - 1;

  ch_state_t         state_q;
  logic [AW-1:0]     next_q, buf_q, fbase_q;
  logic [DW-1:0]     ctrl_q;
  logic [CW-1:0]     cnt_q;
  logic [BYTE_W-1:0] byte_q;
  logic [FIDX_W-1:0] fidx_q;
  logic              stop_req;

  assign stop_req = ctrl_q[CTL_STOP] && ep_irq;

  // outputs decoded from registered state only
  assign mem_req   = (state_q == ST_RD) || (state_q == ST_WR) || (state_q == ST_FETCH);
  assign mem_we    = (state_q == ST_WR);
  assign mem_addr  = (state_q == ST_FETCH) ? fbase_q + AW'(fidx_q) * AW'(WORD_BYTES) : buf_q;
  assign mem_wdata = DW'(byte_q);
  assign out_valid = (state_q == ST_PUSH);
  assign out_data  = byte_q;
  assign in_ready  = (state_q == ST_WAITIN);

  assign active     = (state_q != ST_IDLE);
  assign chan_en    = ctrl_q[CTL_EN];
  assign next_addr  = next_q;
  assign buf_addr   = buf_q;
  assign ctrl_word  = ctrl_q;
  assign remain     = cnt_q;
  assign ev_eob     = (state_q == ST_BDONE);
  assign ev_eob_irq = (state_q == ST_BDONE) && ctrl_q[CTL_IE];
  assign ev_eot     = ((state_q == ST_BDONE) && !ctrl_q[CTL_LD]) ||
                      ((state_q == ST_START) && stop_req);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      next_q  <= '0;
      buf_q   <= '0;
      fbase_q <= '0;
      ctrl_q  <= '0;
      cnt_q   <= '0;
      byte_q  <= '0;
      fidx_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (sw_wr_next) next_q <= sw_wdata[AW-1:0];
          if (sw_wr_buf)  buf_q  <= sw_wdata[AW-1:0];
          if (sw_wr_ctrl) begin
            ctrl_q <= sw_wdata;
            cnt_q  <= sw_wdata[CNT_MSB -: CW];
            if (sw_wdata[CTL_EN]) begin
              state_q <= ST_START;
            end else if (sw_wdata[CTL_LD]) begin
              fbase_q <= next_q;
              fidx_q  <= '0;
              state_q <= ST_FETCH;
            end
          end
        end
        ST_START: begin
          if (stop_req) begin
            ctrl_q[CTL_EN] <= 1'b0;
            state_q        <= ST_IDLE;
          end else if (cnt_q == '0) begin
            state_q <= ST_BDONE;
          end else if (ctrl_q[CTL_DIR]) begin
            state_q <= ST_RD;
          end else begin
            state_q <= ST_WAITIN;
          end
        end
        ST_RD: begin
          if (mem_ack) begin
            byte_q  <= mem_rdata[BYTE_W-1:0];
            state_q <= ST_PUSH;
          end
        end
        ST_PUSH: begin
          if (out_ready) begin
            buf_q   <= buf_q + AW'(1);
            cnt_q   <= cnt_q - CW'(1);
            state_q <= ST_START;
          end
        end
        ST_WAITIN: begin
          if (in_valid) begin
            byte_q  <= in_data;
            state_q <= ST_WR;
          end
        end
        ST_WR: begin
          if (mem_ack) begin
            buf_q   <= buf_q + AW'(1);
            cnt_q   <= cnt_q - CW'(1);
            state_q <= ST_START;
          end
        end
        ST_BDONE: begin
          if (ctrl_q[CTL_LD]) begin
            fbase_q <= next_q;
            fidx_q  <= '0;
            state_q <= ST_FETCH;
          end else begin
            state_q <= ST_IDLE;
          end
        end
        ST_FETCH: begin
          if (mem_ack) begin
            fidx_q <= fidx_q + FIDX_W'(1);
            if (fidx_q == FIDX_W'(0)) begin
              next_q <= mem_rdata[AW-1:0];
            end else if (fidx_q == FIDX_W'(1)) begin
              buf_q <= mem_rdata[AW-1:0];
            end else begin
              ctrl_q  <= mem_rdata;
              cnt_q   <= mem_rdata[CNT_MSB -: CW];
              state_q <= mem_rdata[CTL_EN] ? ST_START : ST_IDLE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R6
  mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R4
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R8
  zero_cnt_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_START && cnt_q == '0 && !stop_req) |=> (!mem_req && !out_valid && !in_ready));

  // R10
  abort_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_START && stop_req) |=> (!active && !chan_en));

  // R3
  next_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (active && !(state_q == ST_FETCH && mem_ack)) |=> $stable(next_q));

endmodule

// File: rtl/ep_dma_channel.sv
module ep_dma_channel
  import ep_dma_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ack,
  output logic          out_valid,
  output logic [7:0]    out_data,
  input  logic          out_ready,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  output logic          in_ready,
  input  logic          ep_irq,
  output logic          dma_irq
);

  logic          sw_wr_next, sw_wr_buf, sw_wr_ctrl;
  logic [AW-1:0] next_addr, buf_addr;
  logic [DW-1:0] ctrl_word;
  logic [CW-1:0] remain;
  logic          active, chan_en;
  logic          ev_eob, ev_eob_irq, ev_eot;

  ep_dma_regs #(.AW(AW), .DW(DW), .CW(CW)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .active     (active),
    .chan_en    (chan_en),
    .next_addr  (next_addr),
    .buf_addr   (buf_addr),
    .ctrl_word  (ctrl_word),
    .remain     (remain),
    .ev_eob     (ev_eob),
    .ev_eob_irq (ev_eob_irq),
    .ev_eot     (ev_eot),
    .sw_wr_next (sw_wr_next),
    .sw_wr_buf  (sw_wr_buf),
    .sw_wr_ctrl (sw_wr_ctrl),
    .dma_irq    (dma_irq)
  );

  ep_dma_engine #(.AW(AW), .DW(DW), .CW(CW)) u_engine (
    .clk        (clk),
    .rst        (rst),
    .sw_wr_next (sw_wr_next),
    .sw_wr_buf  (sw_wr_buf),
    .sw_wr_ctrl (sw_wr_ctrl),
    .sw_wdata   (reg_wdata),
    .ep_irq     (ep_irq),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_rdata  (mem_rdata),
    .mem_ack    (mem_ack),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .out_ready  (out_ready),
    .in_valid   (in_valid),
    .in_data    (in_data),
    .in_ready   (in_ready),
    .next_addr  (next_addr),
    .buf_addr   (buf_addr),
    .ctrl_word  (ctrl_word),
    .remain     (remain),
    .active     (active),
    .chan_en    (chan_en),
    .ev_eob     (ev_eob),
    .ev_eob_irq (ev_eob_irq),
    .ev_eot     (ev_eot)
  );

endmodule

// File: tb/tb_ep_dma_channel.sv
`timescale 1ns/1ps
module tb_ep_dma_channel;

  localparam int MEM_BYTES = 4096;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        mem_ack = 1'b0;
  logic        out_valid;
  logic [7:0]  out_data;
  logic        out_ready = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_ready;
  logic        ep_irq = 1'b0;
  logic        dma_irq;

  ep_dma_channel dut (.*);

  always #10 clk = ~clk;

  logic [7:0] mem    [MEM_BYTES];
  logic [7:0] shadow [MEM_BYTES];
  logic [7:0] got    [256];
  logic [7:0] src    [256];
  int ngot, nsent, nacc, lat;
  bit in_hold;
  int nchk, nfail;

  function automatic logic [7:0] pat(int a);
    return 8'(a * 13 + (a >> 4) + 5);
  endfunction

  function automatic logic [31:0] mk_ctrl(int cnt, bit en, bit ld, bit ie, bit stop, bit dir);
    return {16'(cnt), 11'b0, dir, stop, ie, ld, en};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory responder: random latency, one-cycle ack pulse
  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack <= 1'b0;
    end else if (mem_req && !rst) begin
      if (lat == 0) begin
        int a;
        a = int'(mem_addr[11:0]);
        mem_ack <= 1'b1;
        nacc++;
        if (mem_we) mem[a] = mem_wdata[7:0];
        else mem_rdata <= {mem[(a+3)%MEM_BYTES], mem[(a+2)%MEM_BYTES],
                           mem[(a+1)%MEM_BYTES], mem[a]};
        lat = int'($urandom % 3);
      end else begin
        lat--;
      end
    end
  end

  // stream partners: decide at negedge, transfer happens at next posedge
  always @(negedge clk) begin
    out_ready = (($urandom % 4) != 0);
    if (out_valid && out_ready) begin
      got[ngot % 256] = out_data;
      ngot++;
    end
    in_valid = !in_hold && (($urandom % 3) != 0);
    in_data  = src[nsent % 256];
    if (in_ready && in_valid) nsent++;
  end

  task automatic reg_write(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic wait_quiet();
    int q = 0;
    int t = 0;
    while (q < 8 && t < 5000) begin
      @(negedge clk);
      if (!mem_req && !out_valid && !in_ready) q++; else q = 0;
      t++;
    end
  endtask

  task automatic put_word(int a, logic [31:0] w);
    for (int k = 0; k < 4; k++) mem[a + k] = w[8*k +: 8];
  endtask

  task automatic start_xfer(int buf_a, int cnt, bit ie, bit stop, bit dir);
    ngot = 0; nsent = 0; nacc = 0;
    reg_write(2'd1, 32'(buf_a));
    reg_write(2'd2, mk_ctrl(cnt, 1'b1, 1'b0, ie, stop, dir));
  endtask

  task automatic check_in(string req, int buf_a, int n);
    chk(req, 32'(ngot), 32'(n));
    for (int i = 0; i < n; i++) chk(req, 32'(got[i]), 32'(shadow[buf_a + i]));
  endtask

  task automatic check_out(string req, int buf_a, int n);
    chk(req, 32'(nsent), 32'(n));
    for (int i = 0; i < n; i++) begin
      chk(req, 32'(mem[buf_a + i]), 32'(src[i]));
      shadow[buf_a + i] = src[i];
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd4242));
    for (int i = 0; i < MEM_BYTES; i++) begin
      mem[i] = pat(i);
      shadow[i] = pat(i);
    end
    for (int i = 0; i < 256; i++) src[i] = 8'($urandom);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    chk("R1 mem_req", 32'(mem_req), 0);
    chk("R1 out_valid", 32'(out_valid), 0);
    chk("R1 in_ready", 32'(in_ready), 0);
    chk("R1 dma_irq", 32'(dma_irq), 0);
    reg_read(2'd3, d); chk("R1 status", d, 0);
    reg_read(2'd2, d); chk("R2 ctrl after reset", d, 0);

    // R4 memory to endpoint, with interrupt enable
    start_xfer(32'h100, 5, 1'b1, 1'b0, 1'b1);
    wait_quiet();
    check_in("R4", 32'h100, 5);
    chk("R11 irq raised", 32'(dma_irq), 1);
    reg_read(2'd3, d); chk("R9 R12 status after buffer", d, 32'h0000_000D);
    reg_read(2'd1, d); chk("R2 R4 buffer advanced", d, 32'h105);
    reg_read(2'd3, d); chk("R12 events cleared", d, 32'h0000_0001);
    chk("R12 irq cleared", 32'(dma_irq), 0);

    // R5 endpoint to memory, interrupt disabled
    start_xfer(32'h200, 6, 1'b0, 1'b0, 1'b0);
    wait_quiet();
    check_out("R5", 32'h200, 6);
    chk("R5 access count", 32'(nacc), 6);
    chk("R11 no irq when disabled", 32'(dma_irq), 0);
    reg_read(2'd3, d); chk("R11 eob flag", d, 32'h0000_000D);

    // R3 writes ignored while active
    in_hold = 1'b1;
    start_xfer(32'h280, 4, 1'b0, 1'b0, 1'b0);
    repeat (10) @(negedge clk);
    reg_read(2'd3, d); chk("R3 R12 active status", d, 32'h0004_0003);
    reg_write(2'd0, 32'hABC);
    reg_read(2'd0, d); chk("R3 next unchanged", d, 0);
    reg_write(2'd1, 32'h999);
    reg_read(2'd1, d); chk("R3 buf unchanged", d, 32'h280);
    reg_write(2'd2, 32'h0);
    reg_read(2'd2, d); chk("R3 ctrl unchanged", d, mk_ctrl(4, 1, 0, 0, 0, 0));
    in_hold = 1'b0;
    wait_quiet();
    check_out("R3 R5 after release", 32'h280, 4);
    reg_read(2'd3, d);

    // R7 R8 chain with an empty middle buffer
    put_word(32'h800, 32'h810); put_word(32'h804, 32'h300);
    put_word(32'h808, mk_ctrl(3, 1, 1, 0, 0, 1));
    put_word(32'h810, 32'h820); put_word(32'h814, 32'h340);
    put_word(32'h818, mk_ctrl(0, 1, 1, 1, 0, 1));
    put_word(32'h820, 32'h830); put_word(32'h824, 32'h380);
    put_word(32'h828, mk_ctrl(4, 1, 0, 0, 0, 1));
    ngot = 0; nacc = 0;
    reg_write(2'd0, 32'h800);
    reg_write(2'd2, mk_ctrl(0, 0, 1, 0, 0, 1));
    wait_quiet();
    chk("R7 bytes", 32'(ngot), 7);
    for (int i = 0; i < 3; i++) chk("R7 first buffer", 32'(got[i]), 32'(shadow[32'h300 + i]));
    for (int i = 0; i < 4; i++) chk("R7 last buffer", 32'(got[3 + i]), 32'(shadow[32'h380 + i]));
    chk("R8 access count", 32'(nacc), 16);
    chk("R11 irq from empty buffer", 32'(dma_irq), 1);
    reg_read(2'd0, d); chk("R7 next loaded", d, 32'h830);
    reg_read(2'd1, d); chk("R7 buf loaded", d, 32'h384);
    reg_read(2'd3, d); chk("R9 chain end status", d, 32'h0000_000D);

    // R10 abort on endpoint interrupt
    start_xfer(32'h400, 20, 1'b0, 1'b1, 1'b1);
    for (int t = 0; t < 3000 && ngot < 5; t++) @(negedge clk);
    ep_irq = 1'b1;
    wait_quiet();
    ep_irq = 1'b0;
    chk("R10 stopped early", 32'(ngot < 20), 1);
    check_in("R10 bytes", 32'h400, ngot);
    reg_read(2'd3, d); chk("R10 abort status", d, {16'(20 - ngot), 16'h0004});

    // R10 interrupt ignored without stop bit
    ep_irq = 1'b1;
    start_xfer(32'h500, 6, 1'b0, 1'b0, 1'b1);
    wait_quiet();
    ep_irq = 1'b0;
    check_in("R10 no stop", 32'h500, 6);
    reg_read(2'd3, d);

    // random transfers, both directions, including zero length
    for (int it = 0; it < 20; it++) begin
      int b, n;
      bit dir;
      b = 32'h600 + int'($urandom % 32'h1E0);
      n = int'($urandom % 13);
      dir = 1'($urandom);
      for (int i = 0; i < 256; i++) src[i] = 8'($urandom);
      start_xfer(b, n, 1'b0, 1'b0, dir);
      wait_quiet();
      if (dir) check_in("R4 random", b, n);
      else check_out("R5 random", b, n);
      if (n == 0) chk("R8 no access", 32'(nacc), 0);
      reg_read(2'd3, d); chk("R11 R12 random status", d, 32'h0000_000D);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule